// File: doc/BRIEF.md
# Byte multiplier with signed high-byte correction

This unit multiplies two bytes and keeps the 16-bit result in two byte-wide product registers, the high byte and the low byte. One operand comes from an accumulator register that is written ahead of time through a load strobe. The other operand arrives on the multiply strobe itself. The core multiply is always unsigned and completes on the clock edge that samples the strobe.

When the strobe requests signed mode, the unit stores the unsigned product and then spends two more clock edges fixing the high byte. If the second operand is negative, the first operand is subtracted from the high byte. If the first operand is negative, the second operand is subtracted from the high byte. Both subtractions wrap modulo 256. The low byte is never changed by these steps, and the pair then holds the two's-complement product. The unit drives no arithmetic flags. A busy/done pair tells the surrounding datapath when the registers hold the final product.

Top module: `mul8_signfix`

## Requirements
- R1: When `acc_load` is high at a clock edge, the accumulator takes `acc_data`. A multiply accepted at the same edge uses the accumulator value held before that edge.
- R2: An unsigned multiply (`start` high, `signed_mode` low, unit idle) places the unsigned product of accumulator and `arg_b` in the product registers at that same edge. `done` is high for the following cycle and `busy` stays low.
- R3: `prod_hi` holds bits 15..8 of the product and `prod_lo` holds bits 7..0.
- R4: A signed multiply accepted at edge E0 leaves the 16-bit two's-complement product in the registers after edge E0+2. `done` is high for the cycle after E0+2 and low in the two cycles before it.
- R5: After edge E0+1 of a signed multiply, `prod_hi` equals the unsigned high byte minus the first operand (mod 256) when bit 7 of the second operand is 1. Otherwise it is unchanged.
- R6: After edge E0+2, `prod_hi` is decreased (mod 256) by the second operand when bit 7 of the first operand is 1. Otherwise it is unchanged.
- R7: `prod_lo` keeps its value through both correction edges of a signed multiply.
- R8: `busy` is high for exactly the two cycles between E0 and E0+2. A `start` sampled while `busy` is high is ignored: it does not change the result and produces no extra `done`.
- R9: A synchronous active-low reset clears both product registers and the accumulator, and leaves `busy` and `done` low.
- R10: With no multiply accepted, the product registers keep their value, including while the accumulator is reloaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_load | input | 1 | Write `acc_data` into the accumulator |
| acc_data | input | 8 | New accumulator value |
| start | input | 1 | Multiply strobe; accepted only when idle |
| signed_mode | input | 1 | 1 = signed multiply, 0 = unsigned |
| arg_b | input | 8 | Second operand, sampled with `start` |
| busy | output | 1 | Signed correction in progress |
| done | output | 1 | One-cycle pulse: product registers are final |
| prod_hi | output | 8 | Product high byte |
| prod_lo | output | 8 | Product low byte |

## Verification
Every unsigned operand pair is multiplied back to back while the accumulator is reloaded on the same edge. A design that used the freshly loaded value, or that swapped or truncated the byte halves, produces wrong products. Signed mode is swept over a spread of operands plus every pairing of 0x00, 0x01, 0x7F, 0x80, 0x81 and 0xFF. These cover both correction branches and wrap-around in the high byte, so a missing borrow wrap, a swapped correction order or a correction using the wrong operand shows up as a wrong high byte. Directed runs read the high byte after each correction edge and fire a stray strobe during busy. This catches a design that touches the low byte, takes a new operand mid-sequence or emits an extra done.

// File: rtl/mul8_pkg.sv
// Package: shared types for the byte multiplier.
// Assumes: nothing; pure type definitions.
package mul8_pkg;

    // Sequencer position during a multiply.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIX_B = 2'd1,
        ST_FIX_A = 2'd2
    } mul_state_e;

    // Action applied to the product registers on the coming edge.
    typedef enum logic [1:0] {
        STEP_NONE  = 2'd0,
        STEP_LOAD  = 2'd1,
        STEP_FIX_B = 2'd2,
        STEP_FIX_A = 2'd3
    } prod_step_e;

endpackage

// File: rtl/mul8_array.sv
// Module: combinational unsigned multiplier built from shifted partial products.
// Assumes: both operands unsigned; output is the full 2*W bit product.
module mul8_array #(
    parameter int W = 8
) (
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [2*W-1:0] product
);
    localparam int PW = 2 * W;

    logic [PW-1:0] partial [W];

    // One partial product per multiplier bit.
    for (genvar i = 0; i < W; i++) begin : g_pp
        assign partial[i] = op_b[i] ? ({{W{1'b0}}, op_a} << i) : '0;
    end

    // Sum the partial products.
    always_comb begin
        product = '0;
        for (int k = 0; k < W; k++) begin
            product = product + partial[k];
        end
    end
endmodule

// File: rtl/mul8_seq.sv
// Module: sequencer that accepts multiply strobes and steps signed correction.
// Assumes: start is ignored while busy; signed mode adds two correction edges.
module mul8_seq
    import mul8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       signed_mode,
    output logic       busy,
    output logic       done,
    output prod_step_e step
);
    mul_state_e state_q, state_d;
    logic       accept;
    logic       done_q;

    assign accept = start && (state_q == ST_IDLE);
    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;

    // Decode the product-register action for the coming edge.
    always_comb begin
        case (state_q)
            ST_IDLE:  step = accept ? STEP_LOAD : STEP_NONE;
            ST_FIX_B: step = STEP_FIX_B;
            ST_FIX_A: step = STEP_FIX_A;
            default:  step = STEP_NONE;
        endcase
    end

    // Next-state selection.
    always_comb begin
        case (state_q)
            ST_IDLE:  state_d = (accept && signed_mode) ? ST_FIX_B : ST_IDLE;
            ST_FIX_B: state_d = ST_FIX_A;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State and done-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (accept && !signed_mode) || (state_q == ST_FIX_A);
        end
    end

    AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy); // R8
    AST_BUSY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |=> !busy); // R8
    AST_DONE_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R4
    AST_NO_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R4
endmodule

// File: rtl/mul8_prodreg.sv
// Module: product register pair with operand capture and high-byte correction.
// Assumes: step comes from the sequencer; corrections wrap modulo 2**W.
module mul8_prodreg
    import mul8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  prod_step_e     step,
    input  logic [W-1:0]   in_a,
    input  logic [W-1:0]   in_b,
    input  logic [2*W-1:0] raw_product,
    output logic [W-1:0]   hi,
    output logic [W-1:0]   lo
);
    localparam int MSB = W - 1;

    logic [W-1:0] op_a_q, op_b_q;
    logic [W-1:0] hi_q, lo_q;

    assign hi = hi_q;
    assign lo = lo_q;

    // Hold the operands of the accepted multiply for the correction steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_a_q <= '0;
            op_b_q <= '0;
        end else if (step == STEP_LOAD) begin
            op_a_q <= in_a;
            op_b_q <= in_b;
        end
    end

    // Load the raw product, then apply sign corrections to the high byte only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            case (step)
                STEP_LOAD: begin
                    hi_q <= raw_product[2*W-1:W];
                    lo_q <= raw_product[W-1:0];
                end
                STEP_FIX_B: if (op_b_q[MSB]) hi_q <= hi_q - op_a_q;
                STEP_FIX_A: if (op_a_q[MSB]) hi_q <= hi_q - op_b_q;
                default: ;
            endcase
        end
    end

    AST_LO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_FIX_B || step == STEP_FIX_A) |=> $stable(lo)); // R7
    AST_HI_KEEP_B: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_FIX_B && !op_b_q[MSB]) |=> $stable(hi)); // R5
    AST_HI_KEEP_A: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_FIX_A && !op_a_q[MSB]) |=> $stable(hi)); // R6
endmodule

// File: rtl/mul8_signfix.sv
// Module: top of the byte multiplier with signed high-byte correction.
// Assumes: synchronous active-low reset; drives no status flags.
module mul8_signfix
    import mul8_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc_load,
    input  logic [OPW-1:0] acc_data,
    input  logic           start,
    input  logic           signed_mode,
    input  logic [OPW-1:0] arg_b,
    output logic           busy,
    output logic           done,
    output logic [OPW-1:0] prod_hi,
    output logic [OPW-1:0] prod_lo
);
    localparam int PW = 2 * OPW;

    logic [OPW-1:0] acc_q;
    logic [PW-1:0]  raw_product;
    prod_step_e     step;

    // Accumulator operand register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (acc_load) begin
            acc_q <= acc_data;
        end
    end

    mul8_array #(.W(OPW)) i_array (
        .op_a    (acc_q),
        .op_b    (arg_b),
        .product (raw_product)
    );

    mul8_seq i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .signed_mode (signed_mode),
        .busy        (busy),
        .done        (done),
        .step        (step)
    );

    mul8_prodreg #(.W(OPW)) i_prod (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step),
        .in_a        (acc_q),
        .in_b        (arg_b),
        .raw_product (raw_product),
        .hi          (prod_hi),
        .lo          (prod_lo)
    );

    AST_UNSIGNED_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !signed_mode) |=>
        ({prod_hi, prod_lo} == (PW'($past(acc_q)) * PW'($past(arg_b))))); // R2
    AST_UNSIGNED_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !signed_mode) |=> (done && !busy)); // R2
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (prod_hi == '0 && prod_lo == '0 && !busy && !done)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo))); // R10
endmodule

// File: tb/test_mul8_signfix.sv
module test_mul8_signfix;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_load = 1'b0;
    logic [7:0] acc_data = '0;
    logic       start = 1'b0;
    logic       signed_mode = 1'b0;
    logic [7:0] arg_b = '0;
    logic       busy, done;
    logic [7:0] prod_hi, prod_lo;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;
    logic [7:0] model_acc = '0;

    typedef struct {
        logic [15:0] exp;
        logic [7:0]  a;
        logic [7:0]  b;
        bit          sgn;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;   // 50 MHz

    mul8_signfix i_mul8_signfix (
        .clk(clk), .rst_n(rst_n), .acc_load(acc_load), .acc_data(acc_data),
        .start(start), .signed_mode(signed_mode), .arg_b(arg_b),
        .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [15:0] ref_prod(input logic [7:0] a, input logic [7:0] b,
                                             input bit sgn);
        logic signed [15:0] s;
        if (sgn) begin
            s = 16'($signed(a)) * 16'($signed(b));
            return s;
        end
        return {8'h00, a} * {8'h00, b};
    endfunction

    // Driver: strobe a multiply using the model accumulator, reload it with nxt (R1).
    task automatic issue(input logic [7:0] b, input bit sgn, input logic [7:0] nxt);
        item_t it;
        it.a = model_acc; it.b = b; it.sgn = sgn;
        it.exp = ref_prod(model_acc, b, sgn);
        sb.push_back(it);
        start = 1'b1; signed_mode = sgn; arg_b = b;
        acc_load = 1'b1; acc_data = nxt;
        model_acc = nxt;
        @(negedge clk);
        start = 1'b0; acc_load = 1'b0;
        if (sgn) repeat (2) @(negedge clk);
    endtask

    task automatic preload(input logic [7:0] v);
        acc_load = 1'b1; acc_data = v; model_acc = v;
        @(negedge clk);
        acc_load = 1'b0;
    endtask

    // Monitor: compare each done against the oldest expected item.
    always @(negedge clk) begin
        if (mon_en && rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8", "done with empty scoreboard", {prod_hi, prod_lo}, 16'h0);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (it.sgn)
                    check({prod_hi, prod_lo} == it.exp, "R4",
                          $sformatf("signed %h*%h", it.a, it.b), {prod_hi, prod_lo}, it.exp);
                else
                    check({prod_hi, prod_lo} == it.exp, "R2/R3",
                          $sformatf("unsigned %h*%h", it.a, it.b), {prod_hi, prod_lo}, it.exp);
            end
        end
    end

    function automatic logic [7:0] corner(input int i);
        case (i)
            0: return 8'h00; 1: return 8'h01; 2: return 8'h7F;
            3: return 8'h80; 4: return 8'h81; default: return 8'hFF;
        endcase
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(prod_hi == 0 && prod_lo == 0, "R9", "product in reset", {prod_hi, prod_lo}, 16'h0);
        check(!busy && !done, "R9", "busy/done in reset", {14'h0, busy, done}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 R6 R7: step-by-step signed 0x80 * 0xFF
        preload(8'h80);
        start = 1'b1; signed_mode = 1'b1; arg_b = 8'hFF;
        @(negedge clk); start = 1'b0;
        check({prod_hi, prod_lo} == 16'h7F80, "R4", "raw unsigned after E0", {prod_hi, prod_lo}, 16'h7F80);
        check(busy && !done, "R8", "busy after E0", {14'h0, busy, done}, 16'h2);
        @(negedge clk);
        check(prod_hi == 8'hFF, "R5", "hi after b-sign fix", {8'h0, prod_hi}, 16'h00FF);
        check(prod_lo == 8'h80, "R7", "lo after b-sign fix", {8'h0, prod_lo}, 16'h0080);
        check(busy && !done, "R8", "busy after E1", {14'h0, busy, done}, 16'h2);
        @(negedge clk);
        check(prod_hi == 8'h00, "R6", "hi after a-sign fix", {8'h0, prod_hi}, 16'h0000);
        check(prod_lo == 8'h80, "R7", "lo after a-sign fix", {8'h0, prod_lo}, 16'h0080);
        check(!busy && done, "R4", "done after E2", {14'h0, busy, done}, 16'h1);
        @(negedge clk);
        check(!done, "R4", "done is one pulse", {15'h0, done}, 16'h0);

        // R8: stray start during busy is ignored (0x03 * 0x85 signed = 0xFE8F)
        preload(8'h03);
        start = 1'b1; signed_mode = 1'b1; arg_b = 8'h85;
        @(negedge clk);
        signed_mode = 1'b0; arg_b = 8'h01;          // start still high while busy
        @(negedge clk); start = 1'b0;
        check(prod_hi == 8'hFE, "R5", "hi after b-sign fix, a positive", {8'h0, prod_hi}, 16'h00FE);
        @(negedge clk);
        check({prod_hi, prod_lo} == 16'hFE8F, "R8", "result with stray start", {prod_hi, prod_lo}, 16'hFE8F);
        check(done, "R8", "done after stray start", {15'h0, done}, 16'h1);
        @(negedge clk);
        check(!done, "R8", "no extra done", {15'h0, done}, 16'h0);

        // R10: product holds while accumulator reloads
        preload(8'h55);
        preload(8'hAA);
        check({prod_hi, prod_lo} == 16'hFE8F, "R10", "hold over reload", {prod_hi, prod_lo}, 16'hFE8F);

        // R9: reset clears a nonzero product
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check({prod_hi, prod_lo} == 16'h0, "R9", "reset clears product", {prod_hi, prod_lo}, 16'h0);
        @(negedge clk);

        // Scoreboard sweeps.
        mon_en = 1'b1;
        preload(8'h00);
        // R1 R2 R3: every unsigned pair, accumulator reloaded on each strobe
        for (int idx = 0; idx < 65536; idx++) begin
            logic [15:0] nx;
            nx = 16'(idx + 1);
            issue(idx[7:0], 1'b0, (idx == 65535) ? 8'h00 : nx[15:8]);
        end
        // R4: signed spread
        for (int i = 0; i < 86; i++) begin
            for (int j = 0; j < 86; j++) begin
                int ni;
                ni = (j == 85) ? i + 1 : i;
                issue(8'(j * 3), 1'b1, 8'((ni > 85 ? 0 : ni) * 3));
            end
        end
        // R4 R5 R6: sign corners
        preload(corner(0));
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                int ni;
                ni = (j == 5) ? i + 1 : i;
                issue(corner(j), 1'b1, corner(ni > 5 ? 0 : ni));
            end
        end
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2", "scoreboard drained", 16'(sb.size()), 16'h0);
        finish_run();
    end
endmodule